// File: doc/BRIEF.md
# Dual-Width Host Register Port

This block connects a converter's control logic to a microprocessor bus. The host sees two registers: a 13-bit configuration word that it can only write, and a 13-bit result word that it can only read. The configuration word goes straight to the internal logic. The result word comes in from the conversion engine.

The host bus can be 8 bits or 13 bits wide, and the top bit of the configuration word selects which. After reset the port is in 8-bit mode. In 8-bit mode a flag in the low configuration byte steers the next write into the upper byte, and the flag clears itself once that upper byte is written. Reads alternate between the low byte and a sign-extended upper byte. In 13-bit mode every access moves a whole word in one cycle.

A strap input chooses which edge of the write strobe captures the data. The chip select and the strobes are sampled on the system clock, and the chosen edge is found by a registered edge detector. The bus is split into an input, an output and a per-bit output enable.

Top module: `hri_host_port`

## Requirements
- R1: While reset is high and in the cycle after it, the configuration word reads 0, so the port is in 8-bit mode, and every output enable is low.
- R2: In 8-bit mode (configuration bit 12 = 0), a selected read drives output enables 7..0 high and output enables 12..8 low.
- R3: In 8-bit mode with configuration bit 7 (the high-byte flag) at 0, a write stores bus bits 7..0 into configuration bits 7..0, including the flag itself. Bits 12..8 are left unchanged.
- R4: In 8-bit mode with the high-byte flag at 1, a write stores bus bits 4..0 into configuration bits 12..8 and clears the flag. Bits 6..0 are left unchanged, and the following write lands in the low byte again.
- R5: In 8-bit mode, successive reads return result bits 7..0 on bus bits 7..0, then the upper byte, then the low byte again.
- R6: The 8-bit upper byte is {result bit 12 repeated four times, result bits 11..8}, so it carries the result sign-extended to 16 bits.
- R7: In 13-bit mode (configuration bit 12 = 1), a selected read drives all 13 output enables and places the whole result word on the bus.
- R8: In 13-bit mode a write replaces the whole configuration word with bus bits 12..0 whatever bit 7 holds, and the next write also replaces the whole word.
- R9: With the strap high, the data present when the write strobe falls is captured. With the strap low, the data present when it rises is captured.
- R10: Any change of configuration bit 12 returns the read byte pointer to the low byte, so the first 8-bit read after a change returns the low byte.
- R11: With chip select high (inactive), strobes change neither the configuration word nor the output enables.
- R12: When a read completes in the same cycle as a write commits, both take effect: the write updates the configuration word and the read pointer still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wedge_fall | input | 1 | Strap: 1 captures on the falling write edge, 0 on the rising edge |
| bus_in | input | 13 | Data arriving from the host |
| bus_out | output | 13 | Data driven to the host |
| bus_oe | output | 13 | Per-bit output enable for bus_out |
| cfg_word | output | 13 | Configuration word for the internal logic |
| result_word | input | 13 | Result word from the converter, two's complement |

## Verification
A read that ends and a write that commits can land in the same clock cycle. The read ending advances or returns the byte pointer, and the write may set the high-byte flag. The bench provokes the overlap by raising the read strobe and dropping the write strobe at the same instant, with the falling-edge strap selected. It judges the result by two things: the configuration word holds the new byte, and the next write and read each go to the byte that both effects predict.

// File: rtl/hri_pkg.sv
package hri_pkg;
  parameter int DATA_W = 13;
  parameter int BYTE_W = 8;
  parameter int HB_BIT = 7;
  localparam int UP_W   = DATA_W - BYTE_W;
  localparam int WIDE_B = DATA_W - 1;
  localparam int EXT_W  = 2 * BYTE_W - DATA_W + 1;
endpackage

// File: rtl/hri_edge_det.sv
module hri_edge_det #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic now_q, old_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q <= IDLE;
      old_q <= IDLE;
    end else begin
      now_q <= din;
      old_q <= now_q;
    end
  end

  assign level = now_q;
  assign rise  = now_q & ~old_q;
  assign fall  = ~now_q & old_q;
endmodule

// File: rtl/hri_cfg_write.sv
module hri_cfg_write
  import hri_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg,
  output logic              width_chg
);
  logic [DATA_W-1:0] cfg_q, cfg_nxt;

  always_comb begin
    cfg_nxt = cfg_q;
    if (wr_fire) begin
      if (cfg_q[WIDE_B]) begin
        cfg_nxt = wdata;
      end else if (cfg_q[HB_BIT]) begin
        cfg_nxt[DATA_W-1:BYTE_W] = wdata[UP_W-1:0];
        cfg_nxt[HB_BIT] = 1'b0;
      end else begin
        cfg_nxt[BYTE_W-1:0] = wdata[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_nxt;
  end

  assign width_chg = wr_fire & (cfg_nxt[WIDE_B] != cfg_q[WIDE_B]);
  assign cfg = cfg_q;

  p_hb_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !cfg_q[WIDE_B] && cfg_q[HB_BIT]) |=> !cfg_q[HB_BIT]);

  p_wide_whole_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && cfg_q[WIDE_B]) |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/hri_read_path.sv
module hri_read_path
  import hri_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic              rd_active,
  input  logic              rd_done,
  input  logic              width_chg,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] doe
);
  localparam logic [DATA_W-1:0] NARROW_OE = {{UP_W{1'b0}}, {BYTE_W{1'b1}}};

  logic              up_ptr;
  logic [BYTE_W-1:0] byte_sel;
  logic [DATA_W-1:0] dout_q, doe_q;

  always_ff @(posedge clk) begin
    if (rst || width_chg)       up_ptr <= 1'b0;
    else if (rd_done && !wide)  up_ptr <= ~up_ptr;
  end

  always_comb begin
    if (up_ptr) byte_sel = {{EXT_W{result[DATA_W-1]}}, result[DATA_W-2:BYTE_W]};
    else        byte_sel = result[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      doe_q  <= '0;
    end else if (rd_active) begin
      dout_q <= wide ? result : {{UP_W{1'b0}}, byte_sel};
      doe_q  <= wide ? {DATA_W{1'b1}} : NARROW_OE;
    end else begin
      doe_q  <= '0;
    end
  end

  assign dout = dout_q;
  assign doe  = doe_q;

  p_ptr_return_r5: assert property (@(posedge clk) disable iff (rst)
    (up_ptr && rd_done && !width_chg) |=> !up_ptr);

  p_ptr_clear_r10: assert property (@(posedge clk) disable iff (rst)
    width_chg |=> !up_ptr);

  p_wide_no_ptr_r7: assert property (@(posedge clk) disable iff (rst)
    (wide && !up_ptr) |=> !up_ptr);
endmodule

// File: rtl/hri_host_port.sv
module hri_host_port
  import hri_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              wedge_fall,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [DATA_W-1:0] bus_oe,
  output logic [DATA_W-1:0] cfg_word,
  input  logic [DATA_W-1:0] result_word
);
  logic              sel_q, strap_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_lvl, wr_rise, wr_fall;
  logic              rd_lvl, rd_rise, rd_fall;
  logic              wr_fire, rd_active, rd_done, width_chg;
  logic [DATA_W-1:0] cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b1;
      strap_q <= 1'b1;
      data_q  <= '0;
    end else begin
      sel_q   <= sel_n;
      strap_q <= wedge_fall;
      data_q  <= bus_in;
    end
  end

  hri_edge_det #(.IDLE(1'b1)) u_wr_edge (
    .clk(clk), .rst(rst), .din(wr_n),
    .level(wr_lvl), .rise(wr_rise), .fall(wr_fall)
  );

  hri_edge_det #(.IDLE(1'b1)) u_rd_edge (
    .clk(clk), .rst(rst), .din(rd_n),
    .level(rd_lvl), .rise(rd_rise), .fall(rd_fall)
  );

  assign wr_fire   = ~sel_q & (strap_q ? wr_fall : wr_rise);
  assign rd_active = ~sel_q & ~rd_lvl;
  assign rd_done   = ~sel_q & rd_rise;

  hri_cfg_write u_cfg (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wdata(data_q),
    .cfg(cfg), .width_chg(width_chg)
  );

  hri_read_path u_rd (
    .clk(clk), .rst(rst), .wide(cfg[WIDE_B]), .rd_active(rd_active),
    .rd_done(rd_done), .width_chg(width_chg), .result(result_word),
    .dout(bus_out), .doe(bus_oe)
  );

  assign cfg_word = cfg;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cfg_word == '0 && bus_oe == '0));

  p_narrow_oe_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_oe[DATA_W-1:BYTE_W] != '0) |-> $past(cfg[WIDE_B]));

  p_quiet_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    (sel_q && !width_chg) |=> $stable(cfg_word));

  always_comb begin
    if (!rst) begin
      p_oe_group_r2: assert ($countones(bus_oe[BYTE_W-1:0]) == 0 ||
                             $countones(bus_oe[BYTE_W-1:0]) == BYTE_W);
    end
  end

  logic unused_edges;
  assign unused_edges = rd_fall ^ wr_lvl;
endmodule

// File: tb/hri_host_port_bench.sv
module hri_host_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, wedge_fall = 1'b1;
  logic [12:0] bus_in = '0, result_word = '0;
  logic [12:0] bus_out, bus_oe, cfg_word;
  int checks = 0, fails = 0;
  logic [12:0] got_d, got_oe;

  always #10 clk = ~clk;

  hri_host_port u_hri_host_port (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
    .wedge_fall(wedge_fall), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .cfg_word(cfg_word), .result_word(result_word)
  );

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_split(input logic [12:0] a, input logic [12:0] b, input logic sel);
    @(negedge clk); sel_n = sel; bus_in = a; wr_n = 1'b0;
    @(negedge clk); bus_in = b;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    sel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(input logic [12:0] a);
    write_split(a, a, 1'b0);
  endtask

  task automatic do_read(input logic sel);
    @(negedge clk); sel_n = sel; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    got_d = bus_out; got_oe = bus_oe;
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    sel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 cfg", cfg_word, 13'h0000);
    check("R1 oe", bus_oe, 13'h0000);
  endtask

  task automatic t_narrow_write();
    do_write(13'h005A);
    check("R3 low write", cfg_word, 13'h005A);
    do_write(13'h00A3);
    check("R3 flag stored", cfg_word, 13'h00A3);
    do_write(13'h000B);
    check("R4 upper write", cfg_word, 13'h0B23);
    do_write(13'h0011);
    check("R4 back to low", cfg_word, 13'h0B11);
  endtask

  task automatic t_narrow_read();
    result_word = 13'h1A5C;
    do_read(1'b0);
    check("R5 low byte", got_d[7:0], 13'h005C);
    check("R2 oe narrow", got_oe, 13'h00FF);
    do_read(1'b0);
    check("R6 upper neg", got_d[7:0], 13'h00FA);
    check("R2 oe upper", got_oe, 13'h00FF);
    do_read(1'b0);
    check("R5 wrap low", got_d[7:0], 13'h005C);
    result_word = 13'h0345;
    do_read(1'b0);
    check("R6 upper pos", got_d[7:0], 13'h0003);
  endtask

  task automatic t_strap();
    wedge_fall = 1'b0;
    write_split(13'h0021, 13'h0034, 1'b0);
    check("R9 rising edge", cfg_word, 13'h0B34);
    wedge_fall = 1'b1;
    write_split(13'h0056, 13'h0012, 1'b0);
    check("R9 falling edge", cfg_word, 13'h0B56);
  endtask

  task automatic t_deselected();
    write_split(13'h00FF, 13'h00FF, 1'b1);
    check("R11 write ignored", cfg_word, 13'h0B56);
    result_word = 13'h1A5C;
    do_read(1'b1);
    check("R11 no drive", got_oe, 13'h0000);
    do_read(1'b0);
    check("R11 ptr untouched", got_d[7:0], 13'h005C);
  endtask

  task automatic t_wide();
    do_write(13'h0080);
    do_write(13'h0010);
    check("R4 enter wide", cfg_word, 13'h1000);
    do_read(1'b0);
    check("R7 wide data", got_d, 13'h1A5C);
    check("R7 wide oe", got_oe, 13'h1FFF);
    do_write(13'h1080);
    check("R8 whole word", cfg_word, 13'h1080);
    do_write(13'h1055);
    check("R8 flag ignored", cfg_word, 13'h1055);
    do_write(13'h0012);
    check("R8 leave wide", cfg_word, 13'h0012);
    do_read(1'b0);
    check("R10 low after change", got_d[7:0], 13'h005C);
  endtask

  task automatic t_collide();
    wedge_fall = 1'b1;
    @(negedge clk); sel_n = 1'b0; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 upper before", bus_out[7:0], 13'h00FA);
    rd_n = 1'b1; wr_n = 1'b0; bus_in = 13'h00C5;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    sel_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 write landed", cfg_word, 13'h00C5);
    do_write(13'h0002);
    check("R12 upper next", cfg_word, 13'h0245);
    do_read(1'b0);
    check("R12 read returned low", got_d[7:0], 13'h005C);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_narrow_write();
    t_narrow_read();
    t_strap();
    t_deselected();
    t_wide();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule